// File: doc/BRIEF.md
# Multi-Bank GPIO Pad Control Register Block

This block is the register file that configures a set of general-purpose I/O banks. Each bank has up to 32 pins. For every pin, software picks a function code, a drive strength, a pull selection and an output data bit. The block turns that state into per-pin pad controls: output enable, output value, drive, pull, and a decoded function index for the alternate-function router. It also samples the pad inputs through a synchronizer, so the data register can report pin levels.

Access is through a plain 32-bit register port: a byte address, a write strobe, write data and combinational read data. Banks sit one after another at a fixed 0x24-byte stride. Inside a bank, pin 0 always maps to bit 0 of the bank's registers. Reading the data register returns a mix of two sources. Pins in output function return the value they drive, and all other pins return the level seen on the pad.

Top module: `gpio_pad_regs`

## Requirements
- R1: Bank n occupies byte offsets n*0x24 to n*0x24+0x23. Within a bank the words are: function words at +0x00, +0x04, +0x08 and +0x0C; data at +0x10; drive words at +0x14 and +0x18; pull words at +0x1C and +0x20. Address bits 1:0 are ignored.
- R2: Pin p's function code lives in function word p/8, at bits (p mod 8)*4. Only the low 3 bits of that 4-bit slot are stored, and the top bit reads as 0. The stored code appears on pad_func[3*g+2:3*g], where g = bank*PINS_PER_BANK + p.
- R3: Function code 0 makes the pin an input and code 1 makes it an output. The pad output enable is 1 only for code 1, so codes 2 to 7 (alternate functions) leave it at 0.
- R4: Reading the data register returns, for each pin p in bit p, the stored output bit if the pin's code is 1, and the synchronized pad level otherwise.
- R5: A write to the data register replaces the stored bits of every pin of that bank on one clock edge, whatever each pin's function. From the next cycle, pad_out shows all the new bits together.
- R6: Pin p's drive strength is a 2-bit field in drive word p/16, at bits (p mod 16)*2, and it appears on pad_drive[2*g+1:2*g].
- R7: Pin p's pull selection is a 2-bit field in pull word p/16, at bits (p mod 16)*2, and it appears on pad_pull[2*g+1:2*g]. The encoding is 0 for no pull, 1 for pull-up and 2 for pull-down.
- R8: After reset, every function code is 0, every pull field is 0, every drive field is 1 (each drive word reads 0x55555555), and every stored data bit is 0.
- R9: Any byte offset at or beyond NUM_BANKS*0x24 reads as 0. Writes to such an offset change no state.
- R10: A pad input passes through a two-flop synchronizer. A level set up just after a rising edge first appears in the data readback after the second rising edge that follows.
- R11: A write into one bank leaves every register and pad control of the other banks unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe; the write happens on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NUM_BANKS*PINS_PER_BANK | Raw pad input levels, one bit per pin |
| pad_oe | output | NUM_BANKS*PINS_PER_BANK | Pad output enable per pin |
| pad_out | output | NUM_BANKS*PINS_PER_BANK | Stored output value per pin |
| pad_drive | output | 2*NUM_BANKS*PINS_PER_BANK | Drive strength field per pin |
| pad_pull | output | 2*NUM_BANKS*PINS_PER_BANK | Pull selection field per pin |
| pad_func | output | 3*NUM_BANKS*PINS_PER_BANK | Function index per pin |

## Verification
The assertions assume that bus_addr, bus_we and bus_wdata only change away from the rising edge and hold steady across it. They also assume that bus_we is a single-cycle strobe, which makes each write land exactly once. The bench drives every bus signal and every pad input on the falling edge, so both assumptions hold. Pad inputs may change at any cycle. The bench deliberately changes one pad input on a falling edge and then samples the readback between edges to measure the synchronizer delay.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
   // byte distance between consecutive banks
   localparam int BANK_STRIDE = 36;
   localparam int BUS_W       = 32;

   // word index within a bank (byte offset / 4)
   typedef enum logic [3:0] {
      W_FUNC0 = 4'd0,
      W_FUNC1 = 4'd1,
      W_FUNC2 = 4'd2,
      W_FUNC3 = 4'd3,
      W_DATA  = 4'd4,
      W_DRV0  = 4'd5,
      W_DRV1  = 4'd6,
      W_PULL0 = 4'd7,
      W_PULL1 = 4'd8
   } bank_word_e;

   localparam logic [2:0] FN_INPUT   = 3'd0;
   localparam logic [2:0] FN_OUTPUT  = 3'd1;
   localparam logic [1:0] DRV_RESET  = 2'd1;
   localparam logic [1:0] PULL_RESET = 2'd0;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_pad_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
      end
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
   import gpio_pad_pkg::*;
#(
   parameter int PINS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [3:0]        word,
   input  logic              we,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [PINS-1:0]   pin_lvl,
   output logic [BUS_W-1:0]  rdata,
   output logic [PINS*3-1:0] func,
   output logic [PINS*2-1:0] drv,
   output logic [PINS*2-1:0] pul,
   output logic [PINS-1:0]   oe,
   output logic [PINS-1:0]   dout
);
   if (PINS < 1 || PINS > BUS_W) begin : g_bad_pins
      $error("gpio_pad_bank: PINS must lie in 1..32");
   end

   logic wr_en;
   assign wr_en = sel & we;

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      localparam int FW = p / 8;
      localparam int FB = (p % 8) * 4;
      localparam int SW = p / 16;
      localparam int SB = (p % 16) * 2;

      logic [2:0] fn_q;
      logic [1:0] dr_q;
      logic [1:0] pu_q;
      logic       d_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fn_q <= FN_INPUT;
            dr_q <= DRV_RESET;
            pu_q <= PULL_RESET;
            d_q  <= 1'b0;
         end else if (wr_en) begin
            if (word == 4'(FW))                    fn_q <= wdata[FB +: 3];
            if (word == 4'(int'(W_DRV0) + SW))     dr_q <= wdata[SB +: 2];
            if (word == 4'(int'(W_PULL0) + SW))    pu_q <= wdata[SB +: 2];
            if (word == W_DATA)                    d_q  <= wdata[p];
         end
      end

      assign func[p*3 +: 3] = fn_q;
      assign drv[p*2 +: 2]  = dr_q;
      assign pul[p*2 +: 2]  = pu_q;
      assign oe[p]          = (fn_q == FN_OUTPUT);
      assign dout[p]        = d_q;
   end

   always_comb begin
      rdata = '0;
      if (sel) begin
         for (int p = 0; p < PINS; p++) begin
            if (word == 4'(p / 8))
               rdata[(p % 8) * 4 +: 3] = func[p*3 +: 3];
            if (word == W_DATA)
               rdata[p] = oe[p] ? dout[p] : pin_lvl[p];
            if (word == 4'(int'(W_DRV0) + p / 16))
               rdata[(p % 16) * 2 +: 2] = drv[p*2 +: 2];
            if (word == 4'(int'(W_PULL0) + p / 16))
               rdata[(p % 16) * 2 +: 2] = pul[p*2 +: 2];
         end
      end
   end
endmodule

// File: rtl/gpio_pad_regs.sv
module gpio_pad_regs
   import gpio_pad_pkg::*;
#(
   parameter int NUM_BANKS     = 3,
   parameter int PINS_PER_BANK = 32,
   parameter int ADDR_W        = 10,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [ADDR_W-1:0]                    bus_addr,
   input  logic                                 bus_we,
   input  logic [BUS_W-1:0]                     bus_wdata,
   output logic [BUS_W-1:0]                     bus_rdata,
   input  logic [NUM_BANKS*PINS_PER_BANK-1:0]   pad_in,
   output logic [NUM_BANKS*PINS_PER_BANK-1:0]   pad_oe,
   output logic [NUM_BANKS*PINS_PER_BANK-1:0]   pad_out,
   output logic [2*NUM_BANKS*PINS_PER_BANK-1:0] pad_drive,
   output logic [2*NUM_BANKS*PINS_PER_BANK-1:0] pad_pull,
   output logic [3*NUM_BANKS*PINS_PER_BANK-1:0] pad_func
);
   localparam int NPINS     = NUM_BANKS * PINS_PER_BANK;
   localparam int MAP_BYTES = NUM_BANKS * BANK_STRIDE;
   localparam int PB        = PINS_PER_BANK;

   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("gpio_pad_regs: NUM_BANKS must be at least 1");
   end
   if (ADDR_W > 31 || MAP_BYTES > (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_pad_regs: ADDR_W too small for the bank map");
   end

   logic [NPINS-1:0]                pad_lvl;
   logic [NUM_BANKS-1:0][BUS_W-1:0] bank_rd;
   logic [31:0]                     addr32;

   assign addr32 = 32'(bus_addr);

   gpio_pad_sync #(
      .WIDTH (NPINS),
      .STAGES(SYNC_STAGES)
   ) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pad_in),
      .dout (pad_lvl)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [31:0] BASE = 32'(b * BANK_STRIDE);

      logic        hit;
      logic [31:0] off;
      logic [3:0]  widx;
      logic        unused_off;

      assign hit        = (addr32 >= BASE) && (addr32 < BASE + 32'(BANK_STRIDE));
      assign off        = addr32 - BASE;
      assign widx       = off[5:2];
      assign unused_off = ^{off[31:6], off[1:0]};

      gpio_pad_bank #(
         .PINS(PB)
      ) i_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .sel    (hit),
         .word   (widx),
         .we     (bus_we),
         .wdata  (bus_wdata),
         .pin_lvl(pad_lvl[b*PB +: PB]),
         .rdata  (bank_rd[b]),
         .func   (pad_func[b*PB*3 +: PB*3]),
         .drv    (pad_drive[b*PB*2 +: PB*2]),
         .pul    (pad_pull[b*PB*2 +: PB*2]),
         .oe     (pad_oe[b*PB +: PB]),
         .dout   (pad_out[b*PB +: PB])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         bus_rdata = bus_rdata | bank_rd[b];
      end
   end
endmodule

// File: rtl/gpio_pad_regs_chk.sv
module gpio_pad_regs_chk #(
   parameter int NUM_BANKS     = 3,
   parameter int PINS_PER_BANK = 32,
   parameter int ADDR_W        = 10,
   parameter int SYNC_STAGES   = 2
) (
   input logic                                 clk,
   input logic                                 rst_n,
   input logic [ADDR_W-1:0]                    bus_addr,
   input logic                                 bus_we,
   input logic [31:0]                          bus_wdata,
   input logic [31:0]                          bus_rdata,
   input logic [NUM_BANKS*PINS_PER_BANK-1:0]   pad_oe,
   input logic [NUM_BANKS*PINS_PER_BANK-1:0]   pad_out,
   input logic [2*NUM_BANKS*PINS_PER_BANK-1:0] pad_drive,
   input logic [2*NUM_BANKS*PINS_PER_BANK-1:0] pad_pull,
   input logic [3*NUM_BANKS*PINS_PER_BANK-1:0] pad_func
);
   localparam int MAP_BYTES = NUM_BANKS * 36;
   localparam int PB        = PINS_PER_BANK;

   logic [ADDR_W-3:0] wsel;
   logic              unmapped;
   assign wsel     = bus_addr[ADDR_W-1:2];
   assign unmapped = (32'(bus_addr) >= 32'(MAP_BYTES));

   // R5
   data_write_whole_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && wsel == (ADDR_W-2)'(4)) |=> (pad_out[PB-1:0] == $past(bus_wdata[PB-1:0])));

   // R3
   output_code_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && wsel == '0 && bus_wdata[2:0] == 3'd1) |=> pad_oe[0]);

   // R3
   other_code_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && wsel == '0 && bus_wdata[2:0] != 3'd1) |=> !pad_oe[0]);

   // R6
   drive_field_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && wsel == (ADDR_W-2)'(5)) |=> (pad_drive[1:0] == $past(bus_wdata[1:0])));

   // R7
   pull_field_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && wsel == (ADDR_W-2)'(7)) |=> (pad_pull[1:0] == $past(bus_wdata[1:0])));

   // R9
   unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> (bus_rdata == 32'd0));

   // R9
   unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && unmapped) |=> ($stable(pad_func) && $stable(pad_drive) &&
                                $stable(pad_pull) && $stable(pad_out)));

   // R11
   idle_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> ($stable(pad_func) && $stable(pad_drive) &&
                   $stable(pad_pull) && $stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_pad_regs gpio_pad_regs_chk #(
   .NUM_BANKS    (NUM_BANKS),
   .PINS_PER_BANK(PINS_PER_BANK),
   .ADDR_W       (ADDR_W),
   .SYNC_STAGES  (SYNC_STAGES)
) i_gpio_pad_regs_chk (.*);

// File: tb/test_gpio_pad_regs.sv
module test_gpio_pad_regs;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NB = 3;
   localparam int PB = 32;
   localparam int AW = 10;
   localparam int NP = NB * PB;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic            bus_we = 1'b0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NP-1:0]   pad_in = '0;
   logic [NP-1:0]   pad_oe;
   logic [NP-1:0]   pad_out;
   logic [2*NP-1:0] pad_drive;
   logic [2*NP-1:0] pad_pull;
   logic [3*NP-1:0] pad_func;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   gpio_pad_regs #(
      .NUM_BANKS(NB), .PINS_PER_BANK(PB), .ADDR_W(AW), .SYNC_STAGES(2)
   ) i_gpio_pad_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_drive(pad_drive),
      .pad_pull(pad_pull), .pad_func(pad_func)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [31:0] data);
      @(negedge clk);
      bus_addr  = AW'(addr);
      bus_wdata = data;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
      #2;
   endtask

   task automatic rd(input int addr, output logic [31:0] data);
      @(negedge clk);
      bus_addr = AW'(addr);
      bus_we   = 1'b0;
      #2;
      data = bus_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk("R8", "pad_oe any", {31'b0, |pad_oe}, 32'd0);
      chk("R8", "pad_func any", {31'b0, |pad_func}, 32'd0);
      chk("R8", "pad_pull any", {31'b0, |pad_pull}, 32'd0);
      chk("R8", "pad_out any", {31'b0, |pad_out}, 32'd0);
      chk("R8", "pad_drive all one", {31'b0, pad_drive == {NP{2'b01}}}, 32'd1);
      rd(32'h14, v); chk("R8", "bank0 drive word0", v, 32'h5555_5555);
      rd(32'h5C, v); chk("R8", "bank2 drive word0", v, 32'h5555_5555);
      rd(32'h10, v); chk("R8", "bank0 data", v, 32'h0);
   endtask

   task automatic t_func_fields;
      logic [31:0] v;
      wr(32'h00, 32'hFFFF_FFFF);
      rd(32'h00, v); chk("R2", "func word0 top bits dropped", v, 32'h7777_7777);
      chk("R2", "pin0 func", {29'b0, pad_func[2:0]}, 32'd7);
      chk("R2", "pin7 func", {29'b0, pad_func[23:21]}, 32'd7);
      chk("R3", "alt code 7 no oe", {31'b0, pad_oe[0]}, 32'd0);
      wr(32'h04, 32'h0000_0010);
      chk("R2", "pin9 func", {29'b0, pad_func[29:27]}, 32'd1);
      chk("R3", "pin9 oe", {31'b0, pad_oe[9]}, 32'd1);
   endtask

   task automatic t_oe_codes;
      wr(32'h00, 32'h0000_0012);
      chk("R3", "code2 pin0 code1 pin1", pad_oe[31:0], 32'h0000_0202);
      wr(32'h00, 32'h0000_0011);
      chk("R3", "codes1 on pins0,1", pad_oe[31:0], 32'h0000_0203);
   endtask

   task automatic t_data;
      logic [31:0] v;
      logic [31:0] mask;
      pad_in[31:0] = 32'h0F0F_0F0F;
      repeat (3) @(negedge clk);
      chk("R5", "pad_out before data write", pad_out[31:0], 32'h0);
      wr(32'h10, 32'hA5A5_A5A5);
      chk("R5", "pad_out whole bank", pad_out[31:0], 32'hA5A5_A5A5);
      mask = 32'h0000_0203;
      rd(32'h10, v);
      chk("R4", "mixed readback", v, (32'h0F0F_0F0F & ~mask) | (32'hA5A5_A5A5 & mask));
      wr(32'h10, 32'h5A5A_5A5A);
      chk("R5", "pad_out second write", pad_out[31:0], 32'h5A5A_5A5A);
      rd(32'h10, v);
      chk("R4", "mixed readback 2", v, (32'h0F0F_0F0F & ~mask) | (32'h5A5A_5A5A & mask));
   endtask

   task automatic t_sync;
      @(negedge clk);
      bus_addr  = AW'(32'h10);
      bus_we    = 1'b0;
      pad_in[2] = 1'b0;
      #2 chk("R10", "no edge yet", {31'b0, bus_rdata[2]}, 32'd1);
      @(negedge clk);
      #2 chk("R10", "after one edge", {31'b0, bus_rdata[2]}, 32'd1);
      @(negedge clk);
      #2 chk("R10", "after two edges", {31'b0, bus_rdata[2]}, 32'd0);
   endtask

   task automatic t_drive;
      logic [31:0] v;
      wr(32'h60, 32'h0000_000C);
      chk("R6", "bank2 pin17 drive", {30'b0, pad_drive[(64+17)*2 +: 2]}, 32'd3);
      chk("R6", "bank2 pin16 drive", {30'b0, pad_drive[(64+16)*2 +: 2]}, 32'd0);
      chk("R6", "bank2 pin0 drive kept", {30'b0, pad_drive[128 +: 2]}, 32'd1);
      rd(32'h60, v); chk("R6", "bank2 drive word1", v, 32'h0000_000C);
   endtask

   task automatic t_pull;
      logic [31:0] v;
      wr(32'h20, 32'h8000_0004);
      chk("R7", "pin17 pull-up", {30'b0, pad_pull[17*2 +: 2]}, 32'd1);
      chk("R7", "pin31 pull-down", {30'b0, pad_pull[31*2 +: 2]}, 32'd2);
      chk("R7", "pin16 no pull", {30'b0, pad_pull[16*2 +: 2]}, 32'd0);
      rd(32'h20, v); chk("R7", "pull word1", v, 32'h8000_0004);
   endtask

   task automatic t_addr;
      logic [31:0] v;
      rd(32'h23, v); chk("R1", "low address bits ignored on read", v, 32'h8000_0004);
      wr(32'h2F, 32'h0000_0100);
      chk("R1", "bank1 pin18 oe via offset 0x2C", {31'b0, pad_oe[32+18]}, 32'd1);
      rd(32'h2C, v); chk("R1", "bank1 func word2", v, 32'h0000_0100);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      logic [3*NP-1:0] f0;
      logic [2*NP-1:0] d0, p0;
      logic [NP-1:0]   o0;
      rd(32'h6C, v);  chk("R9", "first unmapped offset", v, 32'h0);
      rd(32'h3FC, v); chk("R9", "top offset", v, 32'h0);
      f0 = pad_func; d0 = pad_drive; p0 = pad_pull; o0 = pad_out;
      wr(32'h6C, 32'hFFFF_FFFF);
      wr(32'h3F0, 32'hFFFF_FFFF);
      chk("R9", "func unchanged", {31'b0, pad_func == f0}, 32'd1);
      chk("R9", "drive unchanged", {31'b0, pad_drive == d0}, 32'd1);
      chk("R9", "pull unchanged", {31'b0, pad_pull == p0}, 32'd1);
      chk("R9", "out unchanged", {31'b0, pad_out == o0}, 32'd1);
   endtask

   task automatic t_isolation;
      logic [31:0] v;
      chk("R11", "banks1-2 out", {31'b0, |pad_out[NP-1:32]}, 32'd0);
      rd(32'h38, v); chk("R11", "bank1 drive word0", v, 32'h5555_5555);
      chk("R11", "bank2 func", {31'b0, |pad_func[3*NP-1:3*64]}, 32'd0);
      chk("R11", "bank1 pull", {31'b0, |pad_pull[2*64-1:2*32]}, 32'd0);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #2 t_reset();
      rst_n = 1'b1;
      t_reset();
      t_func_fields();
      t_oe_codes();
      t_data();
      t_sync();
      t_drive();
      t_pull();
      t_addr();
      t_unmapped();
      t_isolation();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule